// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block produces the system reset from two sources. The first is a synchronous flag that says the supply is good. While the flag is low, reset is held. After the flag goes high, the release is delayed by a fixed number of time ticks. The second source is a watchdog that watches the chip-select line. If that line stays at one level for too long, the watchdog forces a reset of the same length. Time is counted in ticks, and one tick lasts a set number of clocks.

The watchdog period comes from a two-bit field held in a small configuration register. A write to that register is taken only when the write-enable latch is set. It is also refused while a lock flag and a low write-protect pin are both active. A parameter sets the polarity of the reset output, active-low or active-high.

Top module: `rst_supervisor`

## Requirements
- R1: One clock after `supply_ok` is sampled low, the reset output is asserted. It stays asserted while `supply_ok` stays low.
- R2: After `supply_ok` returns high, reset releases after `STRETCH_TICKS` ticks. One tick is `PRESCALE` clocks. If `supply_ok` drops during this delay, the delay starts again from zero.
- R3: While `por_n` is low, reset is asserted and the watchdog select is cleared to 00.
- R4: If the watchdog is enabled and `cs_n` stays high for the selected period, reset is asserted.
- R5: If the watchdog is enabled and `cs_n` stays low for the selected period, reset is asserted.
- R6: Each falling edge of `cs_n` restarts the watchdog count. `cs_n` passes through two synchronizer flops before edge detection. A line that falls more often than once per period never causes a reset.
- R7: The select encodes the period: 00 = `WDT_LONG_TICKS`, 01 = `WDT_MID_TICKS`, 10 = `WDT_SHORT_TICKS`, 11 = watchdog disabled.
- R8: A watchdog timeout asserts reset for the same `STRETCH_TICKS` delay. The watchdog then counts again from zero, so a line that is still stuck causes another timeout.
- R9: A pulse on `cfg_wr` loads `cfg_wdt_sel` only if `cfg_wel` is 1 and the lock is not in force. The lock is in force when `cfg_lock_en` is 1 and `cfg_wp_n` is 0. A refused write leaves the select unchanged.
- R10: If `ACTIVE_HIGH` is 1, `rst_out` is high while in reset. If it is 0, `rst_out` is low while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Synchronous supply-valid flag |
| cs_n | input | 1 | Chip-select line watched by the watchdog |
| cfg_wr | input | 1 | Write strobe for the watchdog select |
| cfg_wdt_sel | input | 2 | New watchdog select value |
| cfg_wel | input | 1 | Write-enable latch state |
| cfg_lock_en | input | 1 | Lock flag for the protected group |
| cfg_wp_n | input | 1 | Write-protect pin, active low |
| rst_out | output | 1 | Reset output, polarity set by `ACTIVE_HIGH` |

## Verification
The assertions assume that `supply_ok` is already synchronous to `clk`. They also assume that `por_n` is low at time zero. This lets the lower bound on the release delay be counted from a known point. The bench drives every input at the falling edge of the clock and holds `por_n` low for several cycles at the start. It sets the watchdog to disabled before any supply test, so a watchdog timeout never overlaps a supply-based release.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int ACTIVE_HIGH     = 0,
  parameter int PRESCALE        = 1000,
  parameter int STRETCH_TICKS   = 200,
  parameter int WDT_LONG_TICKS  = 1400,
  parameter int WDT_MID_TICKS   = 600,
  parameter int WDT_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdt_sel,
  input  logic       cfg_wel,
  input  logic       cfg_lock_en,
  input  logic       cfg_wp_n,
  output logic       rst_out
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam int WW = $clog2(WDT_LONG_TICKS + 1);

  logic [PW-1:0] pre_q;
  logic [SW-1:0] st_q;
  logic [WW-1:0] wd_q, wd_limit;
  logic [1:0]    cs_sync;
  logic          cs_prev, hold_q;
  logic [1:0]    wdt_sel_q;

  wire tick    = (pre_q == PW'(PRESCALE - 1));
  wire cs_fall = cs_prev & ~cs_sync[1];
  wire wd_en   = (wdt_sel_q != 2'b11);
  wire cfg_ok  = cfg_wr & cfg_wel & ~(cfg_lock_en & ~cfg_wp_n);
  wire wd_fire = ~hold_q & wd_en & tick & ~cs_fall & (wd_q >= wd_limit - WW'(1));

  always_comb begin
    case (wdt_sel_q)
      2'b00:   wd_limit = WW'(WDT_LONG_TICKS);
      2'b01:   wd_limit = WW'(WDT_MID_TICKS);
      default: wd_limit = WW'(WDT_SHORT_TICKS);
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q     <= '0;
      st_q      <= '0;
      wd_q      <= '0;
      hold_q    <= 1'b1;
      cs_sync   <= 2'b11;
      cs_prev   <= 1'b1;
      wdt_sel_q <= 2'b00;
    end else begin
      cs_sync <= {cs_sync[0], cs_n};
      cs_prev <= cs_sync[1];
      if (cfg_ok) wdt_sel_q <= cfg_wdt_sel;

      if (!supply_ok || tick) pre_q <= '0;
      else                    pre_q <= pre_q + PW'(1);

      if (!supply_ok) begin
        hold_q <= 1'b1;
        st_q   <= '0;
      end else if (hold_q) begin
        if (tick) begin
          if (st_q == SW'(STRETCH_TICKS - 1)) begin
            hold_q <= 1'b0;
            st_q   <= '0;
          end else begin
            st_q <= st_q + SW'(1);
          end
        end
      end else if (wd_fire) begin
        hold_q <= 1'b1;
        st_q   <= '0;
      end

      if (hold_q || !wd_en || cs_fall || wd_fire) wd_q <= '0;
      else if (tick)                              wd_q <= wd_q + WW'(1);
    end
  end

  generate
    if (ACTIVE_HIGH != 0) begin : g_hi
      assign rst_out = hold_q;
    end else begin : g_lo
      assign rst_out = ~hold_q;
    end
  endgenerate
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int ACTIVE_HIGH   = 0,
  parameter int PRESCALE      = 1000,
  parameter int STRETCH_TICKS = 200
) (
  input logic       clk,
  input logic       por_n,
  input logic       supply_ok,
  input logic       cfg_wr,
  input logic       cfg_wel,
  input logic       cfg_lock_en,
  input logic       cfg_wp_n,
  input logic [1:0] wdt_sel_q,
  input logic       rst_out
);
  wire in_rst = (ACTIVE_HIGH != 0) ? rst_out : ~rst_out;
  int unsigned ok_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          ok_run <= 0;
    else if (!supply_ok) ok_run <= 0;
    else if (ok_run < 32'hFFFF_0000) ok_run <= ok_run + 1;
  end

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> in_rst);

  assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(in_rst) |-> $past(supply_ok));

  assert_release_min_delay_R2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(in_rst) |-> (ok_run >= (STRETCH_TICKS - 1) * PRESCALE));

  assert_disabled_no_reset_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!$past(in_rst) && $past(supply_ok) && $past(wdt_sel_q) == 2'b11) |-> !in_rst);

  assert_locked_write_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr && cfg_lock_en && !cfg_wp_n) |=> $stable(wdt_sel_q));

  assert_no_wel_write_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr && !cfg_wel) |=> $stable(wdt_sel_q));
endmodule

bind rst_supervisor rst_supervisor_chk #(
  .ACTIVE_HIGH(ACTIVE_HIGH), .PRESCALE(PRESCALE), .STRETCH_TICKS(STRETCH_TICKS)
) u_chk (
  .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .cfg_wr(cfg_wr),
  .cfg_wel(cfg_wel), .cfg_lock_en(cfg_lock_en), .cfg_wp_n(cfg_wp_n),
  .wdt_sel_q(wdt_sel_q), .rst_out(rst_out)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int P = 4, S = 10, WL = 40, WM = 24, WS = 12;

  logic clk = 0, por_n = 0, supply_ok = 0, cs_n = 1;
  logic cfg_wr = 0, cfg_wel = 0, cfg_lock_en = 0, cfg_wp_n = 1;
  logic [1:0] cfg_wdt_sel = 2'b00;
  logic rst_lo, rst_hi;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rst_supervisor #(.ACTIVE_HIGH(0), .PRESCALE(P), .STRETCH_TICKS(S),
    .WDT_LONG_TICKS(WL), .WDT_MID_TICKS(WM), .WDT_SHORT_TICKS(WS)) i_rst_supervisor (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .cs_n(cs_n), .cfg_wr(cfg_wr),
    .cfg_wdt_sel(cfg_wdt_sel), .cfg_wel(cfg_wel), .cfg_lock_en(cfg_lock_en),
    .cfg_wp_n(cfg_wp_n), .rst_out(rst_lo));

  rst_supervisor #(.ACTIVE_HIGH(1), .PRESCALE(P), .STRETCH_TICKS(S),
    .WDT_LONG_TICKS(WL), .WDT_MID_TICKS(WM), .WDT_SHORT_TICKS(WS)) i_rst_supervisor_hi (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .cs_n(cs_n), .cfg_wr(cfg_wr),
    .cfg_wdt_sel(cfg_wdt_sel), .cfg_wel(cfg_wel), .cfg_lock_en(cfg_lock_en),
    .cfg_wp_n(cfg_wp_n), .rst_out(rst_hi));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sel(input logic [1:0] v, input logic wel, input logic lk, input logic wp);
    cfg_wdt_sel = v; cfg_wel = wel; cfg_lock_en = lk; cfg_wp_n = wp; cfg_wr = 1;
    cyc(1);
    cfg_wr = 0; cfg_wel = 0; cfg_lock_en = 0; cfg_wp_n = 1;
  endtask

  task automatic wait_release(input string req);
    int n = 0;
    while (rst_lo == 0 && n < 400) begin cyc(1); n++; end
    check(rst_lo == 1, req, rst_lo, 1);
  endtask

  task automatic power_cycle;
    supply_ok = 0; cyc(3); supply_ok = 1;
    wait_release("R2");
  endtask

  task automatic t_por;
    cyc(1);
    check(rst_lo == 0, "R3", rst_lo, 0);
    check(rst_hi == 1, "R10", rst_hi, 1);
    por_n = 1; cyc(2);
    write_sel(2'b11, 1, 0, 1);
  endtask

  task automatic t_power_up;
    supply_ok = 1;
    cyc((S - 1) * P);
    check(rst_lo == 0, "R2 still held", rst_lo, 0);
    cyc(3 * P);
    check(rst_lo == 1, "R2 released", rst_lo, 1);
    check(rst_hi == 0, "R10 high variant released", rst_hi, 0);
  endtask

  task automatic t_supply_drop;
    supply_ok = 0; cyc(2);
    check(rst_lo == 0, "R1 drop asserts", rst_lo, 0);
    check(rst_hi == 1, "R10 high variant asserts", rst_hi, 1);
    cyc(20);
    check(rst_lo == 0, "R1 held while low", rst_lo, 0);
    supply_ok = 1; cyc(30);
    supply_ok = 0; cyc(2); supply_ok = 1;
    cyc((S - 1) * P);
    check(rst_lo == 0, "R2 restart after glitch", rst_lo, 0);
    cyc(3 * P);
    check(rst_lo == 1, "R2 release after glitch", rst_lo, 1);
  endtask

  task automatic t_disabled;
    int bad = 0;
    cs_n = 1;
    for (int i = 0; i < 250; i++) begin cyc(1); if (rst_lo == 0) bad++; end
    check(bad == 0, "R7 disabled never fires", bad, 0);
  endtask

  task automatic t_stuck(input logic lvl, input string req);
    write_sel(2'b10, 1, 0, 1);
    cs_n = lvl;
    power_cycle();
    cyc(WS * P - 8);
    check(rst_lo == 1, {req, " before short period"}, rst_lo, 1);
    cyc(16);
    check(rst_lo == 0, {req, " short timeout"}, rst_lo, 0);
  endtask

  task automatic t_repeat;
    wait_release("R8 stretch after timeout");
    cyc(WS * P - 8);
    check(rst_lo == 1, "R8 counter restarted", rst_lo, 1);
    cyc(16);
    check(rst_lo == 0, "R8 fires again", rst_lo, 0);
  endtask

  task automatic t_kick;
    int bad = 0;
    write_sel(2'b10, 1, 0, 1);
    cs_n = 1;
    power_cycle();
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 30; j++) begin
        cs_n = (j < 15); cyc(1); if (rst_lo == 0) bad++;
      end
    end
    check(bad == 0, "R6 kicked watchdog quiet", bad, 0);
  endtask

  task automatic t_period(input logic [1:0] sel, input int ticks, input string req);
    write_sel(sel, 1, 0, 1);
    cs_n = 1;
    power_cycle();
    cyc(ticks * P - 8);
    check(rst_lo == 1, {req, " before period"}, rst_lo, 1);
    cyc(16);
    check(rst_lo == 0, {req, " at period"}, rst_lo, 0);
  endtask

  task automatic t_lock;
    int bad = 0;
    write_sel(2'b11, 1, 0, 1);
    cs_n = 1;
    power_cycle();
    write_sel(2'b10, 1, 1, 0);
    for (int i = 0; i < 120; i++) begin cyc(1); if (rst_lo == 0) bad++; end
    check(bad == 0, "R9 locked write refused", bad, 0);
    bad = 0;
    write_sel(2'b10, 0, 0, 1);
    for (int i = 0; i < 120; i++) begin cyc(1); if (rst_lo == 0) bad++; end
    check(bad == 0, "R9 no-latch write refused", bad, 0);
    write_sel(2'b10, 1, 1, 1);
    cyc(WS * P - 8);
    check(rst_lo == 1, "R9 accepted write timing", rst_lo, 1);
    cyc(16);
    check(rst_lo == 0, "R9 accepted write fires", rst_lo, 0);
  endtask

  initial begin
    t_por();
    t_power_up();
    t_supply_drop();
    t_disabled();
    t_stuck(1'b1, "R4");
    t_repeat();
    t_stuck(1'b0, "R5");
    t_kick();
    t_period(2'b00, WL, "R7 long");
    t_period(2'b01, WM, "R7 mid");
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) if (por_n && rst_lo == rst_hi) begin
    checks++; errors++;
    $display("FAIL R10 polarity actual=%0d expected=%0d", rst_hi, !rst_lo);
  end
endmodule